// File: doc/BRIEF.md
# Frame-Aligned Multi-Lane Sample Deserializer

This block turns eight serial sample lanes back into parallel words. Each lane carries one 10-bit sample per frame period, least significant bit first. A frame marker, sampled with the data, goes high on the first bit of every word. The block runs on a receive clock that is a multiple of the bit rate. A clock enable, `bit_en`, marks the cycles that carry a bit. Lane and marker inputs are only looked at in those cycles.

The block finds the marker's rising edge and uses it to set word boundaries. When the tenth bit of a word arrives, all eight words are presented together with a single-cycle strobe. A format input selects whether incoming offset-binary words are converted to two's complement by inverting the top bit.

A per-lane checker compares each received word with a fixed test word and keeps a sticky error bit for every lane that differs. If a marker edge arrives in the middle of a word, a one-cycle alignment flag is raised and the block realigns on that edge.

Top module: `sdes_top`

## Requirements
- R1: After reset, `word_valid`, `align_lost`, every bit of `words` and every bit of `test_err` are 0.
- R2: Bits are assembled least significant first: the k-th enabled bit after a word starts, counting from 0, lands in bit k of that lane's 10-bit word (lane n occupies `words[n*10 +: 10]`).
- R3: An enabled cycle in which `frame_in` is 1 while it was 0 in the previous enabled cycle starts a word: that cycle's lane bit is bit 0.
- R4: `word_valid` is high for exactly one cycle, the cycle after the enabled cycle carrying bit 9. All eight lane words are updated together at that point and hold until the next strobe.
- R5: Before the first marker rising edge after reset, no word is produced and `word_valid` stays 0.
- R6: With `fmt_offset` = 1, bit 9 of each word is inverted, so 0x3FF becomes 0x1FF (+511) and 0x000 becomes 0x200 (-512). With `fmt_offset` = 0, words pass unchanged.
- R7: A marker rising edge that arrives when the previous word is not at bit 9 pulses `align_lost` for one cycle. The partial word is dropped, and the next word is assembled starting from that edge.
- R8: When a word completes while `chk_en` = 1, the lane's `test_err` bit is set if its received word, before format conversion, differs from 10'b0001011101 (bit 9 first, 0x05D). A matching word, or any word received with `chk_en` = 0, sets nothing.
- R9: `test_err` bits are sticky. They stay set until `chk_clr` is 1, which clears all of them, and a clear takes priority over a mismatch in the same cycle.
- R10: In cycles with `bit_en` = 0, `lane_in` and `frame_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks cycles that carry one serial bit |
| frame_in | input | 1 | Frame marker, high on the first bit of a word |
| lane_in | input | 8 | One serial bit per lane |
| fmt_offset | input | 1 | 1: input is offset binary, invert bit 9 |
| chk_en | input | 1 | Enable test-word comparison |
| chk_clr | input | 1 | Clear all sticky test error bits |
| words | output | 80 | Eight 10-bit words, lane n at bits n*10 +: 10 |
| word_valid | output | 1 | One-cycle strobe when new words are presented |
| align_lost | output | 1 | One-cycle pulse on a mid-word marker edge |
| test_err | output | 8 | Sticky per-lane test-word mismatch |

## Verification
The assertions assume the marker and lane bits are steady for the whole enabled cycle. They also assume each word spans at least two enabled cycles, so a completed word and a new marker edge never fall in the same bit. The stimulus keeps to this by driving inputs on the falling clock edge only. Every frame holds the marker high for the first half of its bits and low for the rest. Stall cycles with toggled garbage are placed only between bits, and the one misaligned case restarts six bits into a word.

// File: rtl/sdes_pkg.sv
package sdes_pkg;
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } sdes_fmt_e;

  localparam int unsigned SDES_LANES_DEF  = 8;
  localparam int unsigned SDES_WORD_W_DEF = 10;
endpackage

// File: rtl/sdes_frame_ctl.sv
module sdes_frame_ctl #(
  parameter int unsigned WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_in,
  output logic word_done,
  output logic locked,
  output logic align_err
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             frame_q, frame_n;
  logic             lock_q, lock_n;
  logic             align_q, align_n;
  logic             rise;

  always_comb begin
    rise    = bit_en && frame_in && !frame_q;
    frame_n = bit_en ? frame_in : frame_q;
    lock_n  = lock_q || rise;
    if (rise) begin
      cnt_n = '0;
    end else if (bit_en && lock_q) begin
      cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_n = cnt_q;
    end
    align_n   = rise && (cnt_q != LAST);
    word_done = bit_en && lock_n && !rise && (cnt_n == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= LAST;
      frame_q <= 1'b0;
      lock_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      frame_q <= frame_n;
      lock_q  <= lock_n;
      align_q <= align_n;
    end
  end

  assign locked    = lock_q;
  assign align_err = align_q;

  a_r7_resync_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    align_q |-> (cnt_q == '0));
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r5_idle_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> (cnt_q == LAST));
  a_r10_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q) && $stable(frame_q));
endmodule

// File: rtl/sdes_lane.sv
module sdes_lane #(
  parameter int unsigned       WORD_W    = 10,
  parameter logic [WORD_W-1:0] TEST_WORD = 10'b0001011101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              word_done,
  input  logic              fmt_offset,
  input  logic              chk_en,
  input  logic              chk_clr,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic [WORD_W-1:0] raw;
  logic              err_q, err_n;

  always_comb begin
    raw    = {bit_in, sh_q[WORD_W-1:1]};
    sh_n   = bit_en ? raw : sh_q;
    word_n = word_q;
    if (word_done) begin
      word_n = fmt_offset ? (raw ^ MSB_MASK) : raw;
    end
    if (chk_clr) begin
      err_n = 1'b0;
    end else if (word_done && chk_en && (raw != TEST_WORD)) begin
      err_n = 1'b1;
    end else begin
      err_n = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      word_q <= word_n;
      err_q  <= err_n;
    end
  end

  assign word_o = word_q;
  assign err_o  = err_q;

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !chk_clr) |=> err_q);
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clr |=> !err_q);
  a_r4_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(word_q));
endmodule

// File: rtl/sdes_top.sv
module sdes_top #(
  parameter int unsigned LANES  = sdes_pkg::SDES_LANES_DEF,
  parameter int unsigned WORD_W = sdes_pkg::SDES_WORD_W_DEF,
  parameter logic [WORD_W-1:0] TEST_WORD = 10'b0001011101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    frame_in,
  input  logic [LANES-1:0]        lane_in,
  input  logic                    fmt_offset,
  input  logic                    chk_en,
  input  logic                    chk_clr,
  output logic [LANES*WORD_W-1:0] words,
  output logic                    word_valid,
  output logic                    align_lost,
  output logic [LANES-1:0]        test_err
);
  logic word_done;
  logic locked;
  logic valid_q;

  sdes_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .frame_in  (frame_in),
    .word_done (word_done),
    .locked    (locked),
    .align_err (align_lost)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdes_lane #(.WORD_W(WORD_W), .TEST_WORD(TEST_WORD)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .bit_in     (lane_in[g]),
      .word_done  (word_done),
      .fmt_offset (fmt_offset),
      .chk_en     (chk_en),
      .chk_clr    (chk_clr),
      .word_o     (words[g*WORD_W +: WORD_W]),
      .err_o      (test_err[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= word_done;
    end
  end

  assign word_valid = valid_q;

  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r5_no_valid_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !word_valid);
  a_r7_no_word_on_resync: assert property (@(posedge clk) disable iff (!rst_n)
    align_lost |-> !word_valid);
endmodule

// File: tb/test_sdes_top.sv
module test_sdes_top;
  localparam int LANES = 8;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_en, frame_in, fmt_offset, chk_en, chk_clr;
  logic [LANES-1:0] lane_in;
  logic [LANES*W-1:0] words;
  logic word_valid, align_lost;
  logic [LANES-1:0] test_err;

  int checks = 0;
  int errors = 0;
  int valid_cnt = 0;
  int align_cnt = 0;
  logic [LANES*W-1:0] exp_q[$];

  always #5 clk = ~clk;

  sdes_top i_sdes_top (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_in(frame_in),
    .lane_in(lane_in), .fmt_offset(fmt_offset), .chk_en(chk_en),
    .chk_clr(chk_clr), .words(words), .word_valid(word_valid),
    .align_lost(align_lost), .test_err(test_err)
  );

  task automatic check(input string req, input logic [LANES*W-1:0] act,
                       input logic [LANES*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare every strobe against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (align_lost === 1'b1) align_cnt++;
      if (word_valid === 1'b1) begin
        valid_cnt++;
        if (exp_q.size() == 0) begin
          check("R5 unexpected strobe", 80'(word_valid), 80'(0));
        end else begin
          check("R2 R4 R6 words", words, exp_q.pop_front());
        end
      end
    end
  end

  function automatic logic [LANES*W-1:0] conv(input logic [LANES*W-1:0] raw,
                                             input logic off);
    logic [LANES*W-1:0] r = raw;
    for (int k = 0; k < LANES; k++) if (off) r[k*W + W-1] = ~r[k*W + W-1];
    return r;
  endfunction

  task automatic drive_bit(input logic [LANES-1:0] b, input logic f);
    @(negedge clk);
    bit_en = 1'b1; lane_in = b; frame_in = f;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0; lane_in = ~lane_in; frame_in = ~frame_in;
    end
  endtask

  // one full frame; stall inserts disabled cycles with garbage between bits
  task automatic send_frame(input logic [LANES*W-1:0] raw, input bit stall);
    exp_q.push_back(conv(raw, fmt_offset));
    for (int i = 0; i < W; i++) begin
      logic [LANES-1:0] b;
      for (int k = 0; k < LANES; k++) b[k] = raw[k*W + i];
      drive_bit(b, i < W/2);
      if (stall && (i % 3 == 1)) idle(2);
    end
    @(negedge clk);
    bit_en = 1'b0; frame_in = 1'b0;
  endtask

  function automatic logic [LANES*W-1:0] fill(input logic [W-1:0] v);
    logic [LANES*W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*W +: W] = v;
    return r;
  endfunction

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LANES*W-1:0] pat;
    rst_n = 1'b0; bit_en = 1'b0; frame_in = 1'b0; lane_in = '0;
    fmt_offset = 1'b0; chk_en = 1'b0; chk_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 words", words, '0);
    check("R1 flags", {68'(0), word_valid, align_lost, 2'b00, test_err},
          {68'(0), 1'b0, 1'b0, 2'b00, 8'h00});
    rst_n = 1'b1;

    // R5: bits without any marker edge
    for (int i = 0; i < 7; i++) drive_bit(8'hA5 ^ 8'(i), 1'b0);
    idle(3);
    check("R5 no strobe before lock", 80'(valid_cnt), 80'(0));

    // R2 R3 R4: several patterns, two's complement pass-through
    for (int k = 0; k < LANES; k++) pat[k*W +: W] = 10'(k * 73 + 5);
    send_frame(pat, 1'b0);
    send_frame(fill(10'h3FF), 1'b0);
    send_frame(fill(10'h2AA), 1'b0);
    for (int k = 0; k < LANES; k++) pat[k*W +: W] = 10'(1 << k);
    send_frame(pat, 1'b0);
    idle(2);
    check("R4 strobe count", 80'(valid_cnt), 80'(4));
    check("R7 no alignment loss on clean frames", 80'(align_cnt), 80'(0));

    // R6: offset binary conversion
    fmt_offset = 1'b1;
    pat = {10'h3FF, 10'h000, 10'h200, 10'h1FF, 10'h001, 10'h3FE, 10'h155, 10'h0F0};
    send_frame(pat, 1'b0);
    idle(2);
    check("R6 0x3FF to +511", 80'(words[7*W +: W]), 80'(10'h1FF));
    check("R6 0x000 to -512", 80'(words[6*W +: W]), 80'(10'h200));
    fmt_offset = 1'b0;

    // R10: stalls with garbage between bits
    for (int k = 0; k < LANES; k++) pat[k*W +: W] = 10'(k * 111 + 17);
    send_frame(pat, 1'b1);
    idle(2);

    // R7: marker restarts six bits into a word
    for (int i = 0; i < 6; i++) drive_bit(8'hFF, i < 3);
    for (int k = 0; k < LANES; k++) pat[k*W +: W] = 10'(k * 29 + 300);
    send_frame(pat, 1'b0);
    idle(2);
    check("R7 one alignment pulse", 80'(align_cnt), 80'(1));
    check("R7 partial word dropped", 80'(valid_cnt), 80'(7));

    // R8: checker with one mismatching lane
    chk_en = 1'b1;
    pat = fill(10'h05D);
    pat[3*W +: W] = 10'h05C;
    send_frame(pat, 1'b0);
    check("R8 mismatch lane flagged", 80'(test_err), 80'(8'h08));
    send_frame(fill(10'h05D), 1'b0);
    check("R9 error sticky", 80'(test_err), 80'(8'h08));
    @(negedge clk); chk_clr = 1'b1;
    @(negedge clk); chk_clr = 1'b0;
    check("R9 clear", 80'(test_err), 80'(0));
    send_frame(fill(10'h05D), 1'b0);
    check("R8 match sets nothing", 80'(test_err), 80'(0));

    // R9: clear held while a mismatch completes
    chk_clr = 1'b1;
    send_frame(fill(10'h000), 1'b0);
    check("R9 clear wins", 80'(test_err), 80'(0));
    chk_clr = 1'b0;

    // R8: checking disabled
    chk_en = 1'b0;
    send_frame(fill(10'h3C3), 1'b0);
    check("R8 disabled sets nothing", 80'(test_err), 80'(0));

    idle(3);
    check("R4 all expected words seen", 80'(exp_q.size()), 80'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule